// File: doc/BRIEF.md
# Dual Card Channel Select Router

This block connects one host-side card interface (a reset level, a sampled card clock and an open-drain data line) to one of two card channels. A single select input picks the channel that talks to the host. The other channel stays powered and initialised. Its reset level is frozen, its I/O is cut off from the host and pulled high, and its clock either keeps running or is stopped cleanly. Each channel also receives a registered voltage code for its regulator.

Every output is registered on the system clock, so any input change shows at the outputs one system cycle later. The card clock source is sampled as a slow data signal. Gating decisions are made only in cycles where that sample is low, which keeps every clock pulse that reaches a card at full width. A channel gets nothing until its power sequencer raises its ready flag. The regulators, the level shifters and the pull-up current sources lie outside this block.

Top module: `dual_card_router`

## Requirements
- R1: `sel`=0 makes channel 0 active and `sel`=1 makes channel 1 active. Only a ready, active channel has `card_io_conn` high, so at most one bit of `card_io_conn` is high. That channel alone receives `host_drive_low` on its `card_drive_low` bit. Its `card_low` bit alone is passed on to `host_pull_low`. A selected ready channel's `card_clk` follows the card clock source.
- R2: `vcode[i]` equals `vsel[i]` one cycle later, where 1 means the 3 V mode and 0 means the 1.8 V mode. This holds whatever `sel` and `ch_ready` are.
- R3: While a channel is ready and active, its `card_rst` equals `host_rst` one cycle later.
- R4: While a channel is ready and not active, its `card_rst` keeps the value it had when it was deselected.
- R5: A ready channel that is not active has `card_io_conn`=0 and `card_io_pullhi`=1, and its `card_drive_low`=0.
- R6: A channel whose `ch_ready` is 0 has `card_rst`, `card_clk`, `card_io_conn`, `card_io_pullhi` and `card_drive_low` all at 0 one cycle later.
- R7: A ready channel that is deselected with its `clk_run` bit at 0 has its `card_clk` stopped low by the second falling edge of the card clock source (STOP_EDGES=2). It then stays low.
- R8: A ready channel with its `clk_run` bit at 1 receives the card clock whether or not it is selected.
- R9: `host_pullup` is 1 exactly when both `ch_en` bits were 0 in the previous cycle. Its reset value is 1.
- R10: The clock gate of a channel switches only in cycles where the sampled card clock is low. As long as the channel stays ready, every high pulse on `card_clk` therefore lasts a full source half period.
- R11: A change of `sel` moves the reset and data routing in the very next cycle, with the same one-cycle latency as every other input. Only the clock stop waits for source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Channel select (0: channel 0, 1: channel 1) |
| clk_run | input | 2 | Per-channel keep-clock-running request |
| vsel | input | 2 | Per-channel voltage select (1: 3 V, 0: 1.8 V) |
| ch_en | input | 2 | Per-channel enable, used for the host-side pull-up |
| ch_ready | input | 2 | Per-channel ready flag from the power sequencer |
| host_rst | input | 1 | Host reset level |
| card_clk_src | input | 1 | Card clock source, sampled on `clk` |
| host_drive_low | input | 1 | Host is pulling the data line low |
| card_low | input | 2 | Per-channel card I/O is low |
| host_pull_low | output | 1 | Pull the host data line low |
| host_pullup | output | 1 | Weak pull-up on the host data line enabled |
| card_rst | output | 2 | Per-channel card reset level |
| card_clk | output | 2 | Per-channel gated card clock |
| card_io_conn | output | 2 | Per-channel I/O pass switch closed |
| card_io_pullhi | output | 2 | Per-channel I/O pulled high |
| card_drive_low | output | 2 | Per-channel pull card I/O low |
| vcode | output | 2 | Per-channel regulator voltage code |

## Verification
The hardest state to reach is a deselected channel whose frozen reset differs from the current host reset, while the select toggles in the same cycle as the host reset. A binary-ordered sweep over all 2048 combinations of select, ready, enable, voltage, reset and data inputs flips the select on every step. This lands on many of those freeze points, and a bench model of the latched level checks each one. The clock stop is reached by running the source clock and switching the select at an arbitrary phase. The bench then watches that the old channel falls silent within two source periods and that no high pulse is ever shorter than a half period.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned NCH = 2;
  typedef logic [NCH-1:0] chvec_t;
endpackage

// File: rtl/drt_route.sv
module drt_route (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic active,
  input  logic host_rst,
  input  logic host_drive_low,
  input  logic card_low,
  output logic rst_o,
  output logic conn_o,
  output logic pullhi_o,
  output logic drive_low_o,
  output logic talk_low_o
);
  logic rst_d;
  logic past_ok;

  always_comb begin
    rst_d = rst_o;
    if (!ready)      rst_d = 1'b0;
    else if (active) rst_d = host_rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_o       <= 1'b0;
      conn_o      <= 1'b0;
      pullhi_o    <= 1'b0;
      drive_low_o <= 1'b0;
      talk_low_o  <= 1'b0;
      past_ok     <= 1'b0;
    end else begin
      rst_o       <= rst_d;
      conn_o      <= ready & active;
      pullhi_o    <= ready & ~active;
      drive_low_o <= ready & active & host_drive_low;
      talk_low_o  <= ready & active & card_low;
      past_ok     <= 1'b1;
    end
  end

  AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(ready && active) |-> rst_o == $past(host_rst)); // R3
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(ready && !active) |-> rst_o == $past(rst_o)); // R4
  AST_DESEL_ISOLATE: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(ready && !active) |-> pullhi_o && !conn_o && !drive_low_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(!ready) |-> !rst_o && !conn_o && !pullhi_o && !drive_low_o); // R6
endmodule

// File: rtl/drt_clk_gate.sv
module drt_clk_gate #(
  parameter int unsigned STOP_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic want,
  input  logic src_now,
  input  logic src_prev,
  output logic clk_o
);
  localparam int unsigned CW = $clog2(STOP_EDGES + 1);

  logic          gate_q, gate_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fall;
  logic          past_ok;

  assign fall = src_prev & ~src_now;

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    if (!ready) begin
      gate_d = 1'b0;
      cnt_d  = '0;
    end else if (want) begin
      cnt_d = '0;
      if (!gate_q && !src_now) gate_d = 1'b1;
    end else if (gate_q && fall) begin
      if (cnt_q == CW'(STOP_EDGES - 1)) begin
        gate_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      cnt_q   <= '0;
      clk_o   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      cnt_q   <= cnt_d;
      clk_o   <= gate_d & src_now;
      past_ok <= 1'b1;
    end
  end

  AST_GATE_AT_LOW: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(ready) && (gate_q != $past(gate_q))) |-> !clk_o); // R10
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(!ready) |-> !clk_o); // R6
  AST_RUN_KEEP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(ready && want && gate_q) |-> gate_q); // R8
endmodule

// File: rtl/dual_card_router.sv
module dual_card_router #(
  parameter int unsigned STOP_EDGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic [1:0] clk_run,
  input  logic [1:0] vsel,
  input  logic [1:0] ch_en,
  input  logic [1:0] ch_ready,
  input  logic       host_rst,
  input  logic       card_clk_src,
  input  logic       host_drive_low,
  input  logic [1:0] card_low,
  output logic       host_pull_low,
  output logic       host_pullup,
  output logic [1:0] card_rst,
  output logic [1:0] card_clk,
  output logic [1:0] card_io_conn,
  output logic [1:0] card_io_pullhi,
  output logic [1:0] card_drive_low,
  output logic [1:0] vcode
);
  import drt_pkg::*;

  chvec_t active;
  chvec_t talk_low;
  logic   src_prev;
  logic   past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev    <= 1'b0;
      vcode       <= '0;
      host_pullup <= 1'b1;
      past_ok     <= 1'b0;
    end else begin
      src_prev    <= card_clk_src;
      vcode       <= vsel;
      host_pullup <= ~|ch_en;
      past_ok     <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign active[g] = (sel == 1'(g));

    drt_route u_route (
      .clk            (clk),
      .rst            (rst),
      .ready          (ch_ready[g]),
      .active         (active[g]),
      .host_rst       (host_rst),
      .host_drive_low (host_drive_low),
      .card_low       (card_low[g]),
      .rst_o          (card_rst[g]),
      .conn_o         (card_io_conn[g]),
      .pullhi_o       (card_io_pullhi[g]),
      .drive_low_o    (card_drive_low[g]),
      .talk_low_o     (talk_low[g])
    );

    drt_clk_gate #(.STOP_EDGES(STOP_EDGES)) u_gate (
      .clk      (clk),
      .rst      (rst),
      .ready    (ch_ready[g]),
      .want     (active[g] | clk_run[g]),
      .src_now  (card_clk_src),
      .src_prev (src_prev),
      .clk_o    (card_clk[g])
    );
  end

  assign host_pull_low = |talk_low;

  AST_ONE_TALKER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(card_io_conn)); // R1
  AST_PULL_XOR_CONN: assert property (@(posedge clk) disable iff (rst)
    (card_io_conn & card_io_pullhi) == 2'b00); // R5
  AST_VCODE_TRACK: assert property (@(posedge clk) disable iff (rst || !past_ok)
    vcode == $past(vsel)); // R2
  AST_HOST_PULLUP: assert property (@(posedge clk) disable iff (rst || !past_ok)
    host_pullup == ($past(ch_en) == 2'b00)); // R9
endmodule

// File: tb/tb_dual_card_router.sv
`timescale 1ns/1ps
module tb_dual_card_router;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0;
  logic [1:0] clk_run = '0, vsel = '0, ch_en = '0, ch_ready = '0, card_low = '0;
  logic       host_rst = 1'b0, card_clk_src = 1'b0, host_drive_low = 1'b0;
  logic       host_pull_low, host_pullup;
  logic [1:0] card_rst, card_clk, card_io_conn, card_io_pullhi, card_drive_low, vcode;

  int total = 0, bad = 0;
  bit cgen_on = 0, mon_on = 0, done = 0;
  int glitches = 0;

  always #10 clk = ~clk;

  dual_card_router dut (
    .clk(clk), .rst(rst), .sel(sel), .clk_run(clk_run), .vsel(vsel),
    .ch_en(ch_en), .ch_ready(ch_ready), .host_rst(host_rst),
    .card_clk_src(card_clk_src), .host_drive_low(host_drive_low),
    .card_low(card_low), .host_pull_low(host_pull_low), .host_pullup(host_pullup),
    .card_rst(card_rst), .card_clk(card_clk), .card_io_conn(card_io_conn),
    .card_io_pullhi(card_io_pullhi), .card_drive_low(card_drive_low), .vcode(vcode)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : srcgen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (cgen_on) begin
        if (ph == H - 1) begin ph = 0; card_clk_src = ~card_clk_src; end
        else ph++;
      end
    end
  end

  initial begin : pulsemon
    int run0 = 0, run1 = 0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin run0 = 0; run1 = 0; end
      else begin
        if (card_clk[0]) run0++;
        else begin if (run0 != 0 && run0 != H) glitches++; run0 = 0; end
        if (card_clk[1]) run1++;
        else begin if (run1 != 0 && run1 != H) glitches++; run1 = 0; end
      end
    end
  end

  task automatic watch(input int ch, input int n, output int rises, output int highs);
    logic prev;
    rises = 0; highs = 0;
    prev = card_clk[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (card_clk[ch]) highs++;
      if (card_clk[ch] && !prev) rises++;
      prev = card_clk[ch];
    end
  endtask

  initial begin : watchdog
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [1:0] exp_rst;
    int r, h;
    repeat (3) @(negedge clk);
    // Reset state, R6 and R9
    check("R6 reset card_rst", card_rst, 0);
    check("R6 reset card_clk", card_clk, 0);
    check("R6 reset card_io_conn", card_io_conn, 0);
    check("R6 reset card_io_pullhi", card_io_pullhi, 0);
    check("R9 reset host_pullup", host_pullup, 1);
    check("R2 reset vcode", vcode, 0);
    rst = 1'b0;
    exp_rst = '0;

    // Exhaustive routing sweep: select flips on every step (R11)
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] b;
      b = 11'(v);
      sel = b[0]; ch_ready = b[2:1]; host_rst = b[3]; host_drive_low = b[4];
      card_low = b[6:5]; vsel = b[8:7]; ch_en = b[10:9];
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        bit act, rdy;
        act = (sel == 1'(i));
        rdy = ch_ready[i];
        if (!rdy) exp_rst[i] = 1'b0;
        else if (act) exp_rst[i] = host_rst;
        if (!rdy) begin
          check("R6 idle rst", card_rst[i], 0);
          check("R6 idle conn", card_io_conn[i], 0);
          check("R6 idle pullhi", card_io_pullhi[i], 0);
          check("R6 idle drive_low", card_drive_low[i], 0);
        end else if (act) begin
          check("R3 R11 follow host reset", card_rst[i], exp_rst[i]);
          check("R1 conn", card_io_conn[i], 1);
          check("R1 pullhi off", card_io_pullhi[i], 0);
          check("R1 drive_low", card_drive_low[i], host_drive_low);
        end else begin
          check("R4 hold reset", card_rst[i], exp_rst[i]);
          check("R5 conn off", card_io_conn[i], 0);
          check("R5 pullhi", card_io_pullhi[i], 1);
          check("R5 drive_low off", card_drive_low[i], 0);
        end
      end
      check("R1 host_pull_low", host_pull_low,
            int'((ch_ready[sel] && card_low[sel])));
      check("R2 vcode", vcode, vsel);
      check("R9 host_pullup", host_pullup, int'(ch_en == 2'b00));
    end

    // Clock phase
    @(negedge clk);
    ch_ready = 2'b11; ch_en = 2'b11; sel = 1'b0; clk_run = 2'b00;
    cgen_on = 1;
    repeat (30) @(negedge clk);
    mon_on = 1;
    watch(0, 24, r, h); check("R1 selected channel clock rises", r, 4);
    watch(1, 24, r, h); check("R7 deselected idle clock highs", h, 0);

    sel = 1'b1;
    repeat (14) @(negedge clk);
    watch(0, 12, r, h); check("R7 clock stopped after switch", h, 0);
    watch(1, 24, r, h); check("R1 new channel clock rises", r, 4);

    clk_run = 2'b01;
    repeat (10) @(negedge clk);
    watch(0, 24, r, h); check("R8 run keeps deselected clock", r, 4);
    watch(1, 24, r, h); check("R8 selected still clocked", r, 4);

    check("R10 no short clock pulses", glitches, 0);
    mon_on = 0;

    ch_ready = 2'b10;
    repeat (2) @(negedge clk);
    watch(0, 12, r, h); check("R6 not ready clock silent", h, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule